// File: doc/BRIEF.md
# SPI Register Burst Read Sequencer

This block runs register reads against a metering-style SPI slave. A single request gives a 12-bit register address and a word count. The block then drops chip select and sends a two-byte command header to a byte-level SPI shifter. Next it clocks in four bytes for each requested 32-bit word and then the slave's two trailing CRC bytes. Chip select is released only after the last CRC byte.

The slave sends each word most significant byte first. The sequencer reassembles the bytes so that every word appears on the output stream in native order, with a one-cycle valid strobe. A completion strobe closes the transaction. A warning flag pulses with that strobe when the trailing 16-bit CRC is all zeros, which indicates that the slave has lost frame alignment. The shifter exchanges one byte per handshake: the sequencer offers a byte on `tx_valid`/`tx_data`, the shifter accepts it with `tx_ready`, and the shifter later returns the byte it received with a one-cycle `rx_valid` pulse.

Top module: `spi_burst_reader`

## Requirements
- R1: The first header byte sent is address bits [11:4]; the second is address bits [3:0] in bits [7:4] with bit 3 set to 1 and bits [2:0] zero (read command).
- R2: `cs_n` falls in the cycle after an accepted request and stays low through every byte exchange of the transaction; `tx_valid` is never high while `cs_n` is high.
- R3: A transaction of N words performs exactly 4N+4 byte exchanges: 2 header bytes, then 4N data bytes, then 2 CRC bytes, with no additional exchange anywhere.
- R4: Within each group of four data bytes, the first received byte goes to bits [31:24] and the fourth to bits [7:0]; `word_valid` pulses for one cycle, one cycle after the fourth byte's `rx_valid`.
- R5: Every byte sent during the data and CRC phases is 0x00.
- R6: `crc_zero` is high only together with `done`, and only when the 16-bit CRC (first CRC byte as the high byte) equals 0x0000.
- R7: `done` is a one-cycle pulse after the last CRC byte, with `cs_n` already high in that cycle; `busy` is low in the following cycle.
- R8: A `req_start` while `busy` is high has no effect on the running transaction: the address, the byte count and the words it returns stay unchanged.
- R9: A request with a word count of 0, or above `MAX_WORDS`, is ignored: `busy` stays low and no byte is exchanged.
- R10: After reset, `cs_n` is high and `busy`, `tx_valid`, `word_valid`, `done` and `crc_zero` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | One-cycle request strobe |
| req_addr | input | 12 | Register address to read |
| req_count | input | CNT_W | Number of 32-bit words, 1..MAX_WORDS |
| busy | output | 1 | Transaction in progress |
| cs_n | output | 1 | Slave chip select, active low |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_data | output | 8 | Byte to shift out |
| tx_ready | input | 1 | Shifter accepts the offered byte |
| rx_valid | input | 1 | Shifter finished a byte exchange |
| rx_data | input | 8 | Byte received from the slave |
| word_valid | output | 1 | Output word strobe |
| word_data | output | 32 | Reassembled word in native order |
| done | output | 1 | Transaction complete strobe |
| crc_zero | output | 1 | Trailing CRC was all zeros (lost sync) |

## Verification
The assertions check on every cycle that bytes are offered only while chip select is low, that an offered byte stays stable until the shifter accepts it, that data-phase bytes are zero, that the word and done strobes fall inside and at the end of a transaction, and that the latched address survives a request made while busy. The exact header encoding, the byte count per transaction, the byte order inside each word and whether the CRC flag follows the actual CRC value can only be shown by the bench's scenarios. These scenarios use a shifter model with varying latency, burst lengths from one word up to the maximum, zero and non-zero CRCs, an intruding request and rejected counts.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_DONE
  } rd_state_t;

  localparam logic [7:0] FILL_BYTE = 8'h00;
  localparam logic [3:0] READ_NIBBLE = 4'b1000;

  // sel = 0: first header byte, sel = 1: second header byte
  function automatic logic [7:0] hdr_byte(input logic [11:0] addr, input logic sel);
    if (sel) return {addr[3:0], READ_NIBBLE};
    return addr[11:4];
  endfunction

  // shift a newly received byte in at the low end; earlier bytes move up
  function automatic logic [31:0] push_byte(input logic [31:0] acc, input logic [7:0] b);
    return {acc[23:0], b};
  endfunction

  function automatic logic [15:0] push_crc(input logic [15:0] acc, input logic [7:0] b);
    return {acc[7:0], b};
  endfunction

endpackage

// File: rtl/spi_rd_index.sv
module spi_rd_index #(
  parameter int CNT_W = 7,
  parameter int IDX_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] idx,
  output logic             hdr_phase,
  output logic             data_phase,
  output logic             crc_phase,
  output logic             last_byte,
  output logic             word_end
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] crc_start;

  assign crc_start = IDX_W'({count, 2'b00}) + IDX_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clear) idx_q <= '0;
    else if (step)  idx_q <= idx_q + IDX_W'(1);
  end

  assign idx        = idx_q;
  assign hdr_phase  = idx_q < IDX_W'(2);
  assign data_phase = !hdr_phase && (idx_q < crc_start);
  assign crc_phase  = idx_q >= crc_start;
  assign last_byte  = idx_q == (crc_start + IDX_W'(1));
  assign word_end   = data_phase && (idx_q[1:0] == 2'b01);

endmodule

// File: rtl/spi_rd_assembler.sv
module spi_rd_assembler
  import spi_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        word_end,
  input  logic [7:0]  rx_data,
  output logic        word_valid,
  output logic [31:0] word_data
);

  logic [31:0] acc_q;
  logic [31:0] next_acc;

  assign next_acc = push_byte(acc_q, rx_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= take && word_end;
      if (take) acc_q <= next_acc;
      if (take && word_end) word_data <= next_acc;
    end
  end

endmodule

// File: rtl/spi_rd_crc_capture.sv
module spi_rd_crc_capture
  import spi_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       take,
  input  logic [7:0] rx_data,
  output logic       is_zero
);

  logic [15:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clear) crc_q <= '0;
    else if (take)  crc_q <= push_crc(crc_q, rx_data);
  end

  assign is_zero = crc_q == 16'h0000;

endmodule

// File: rtl/spi_burst_reader.sv
module spi_burst_reader
  import spi_rd_pkg::*;
#(
  parameter int MAX_WORDS = 64,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic [11:0]      req_addr,
  input  logic [CNT_W-1:0] req_count,
  output logic             busy,
  output logic             cs_n,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             word_valid,
  output logic [31:0]      word_data,
  output logic             done,
  output logic             crc_zero
);

  localparam int IDX_W = CNT_W + 2;

  rd_state_t        state_q, state_d;
  logic [11:0]      addr_q;
  logic [CNT_W-1:0] cnt_q;

  // named internal events
  logic             req_ok;
  logic             tx_fire;
  logic             rx_fire;
  logic             pay_phase;
  logic [IDX_W-1:0] idx;
  logic             hdr_phase, data_phase, crc_phase, last_byte, word_end;
  logic             crc_is_zero;

  assign req_ok  = req_start && (state_q == ST_IDLE) && (req_count != '0)
                   && (req_count <= CNT_W'(MAX_WORDS));
  assign tx_fire = tx_valid && tx_ready;
  assign rx_fire = (state_q == ST_WAIT) && rx_valid;
  assign pay_phase = data_phase || crc_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (req_ok) begin
        addr_q <= req_addr;
        cnt_q  <= req_count;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_ok)  state_d = ST_SEND;
      ST_SEND: if (tx_fire) state_d = ST_WAIT;
      ST_WAIT: if (rx_fire) state_d = last_byte ? ST_DONE : ST_SEND;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  spi_rd_index #(.CNT_W(CNT_W), .IDX_W(IDX_W)) i_index (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (req_ok),
    .step      (rx_fire && !last_byte),
    .count     (cnt_q),
    .idx       (idx),
    .hdr_phase (hdr_phase),
    .data_phase(data_phase),
    .crc_phase (crc_phase),
    .last_byte (last_byte),
    .word_end  (word_end)
  );

  spi_rd_assembler i_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (rx_fire && data_phase),
    .word_end  (word_end),
    .rx_data   (rx_data),
    .word_valid(word_valid),
    .word_data (word_data)
  );

  spi_rd_crc_capture i_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (req_ok),
    .take   (rx_fire && crc_phase),
    .rx_data(rx_data),
    .is_zero(crc_is_zero)
  );

  assign busy     = state_q != ST_IDLE;
  assign cs_n     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign tx_valid = state_q == ST_SEND;
  assign tx_data  = hdr_phase ? hdr_byte(addr_q, idx[0]) : FILL_BYTE;
  assign done     = state_q == ST_DONE;
  assign crc_zero = done && crc_is_zero;

endmodule

// File: rtl/spi_rd_checker.sv
module spi_rd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_start,
  input logic        busy,
  input logic        cs_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        pay_phase,
  input logic [11:0] addr_q,
  input logic        word_valid,
  input logic        done,
  input logic        crc_zero
);

  AST_TX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cs_n); // R2

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R3

  AST_PAYLOAD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && pay_phase |-> tx_data == 8'h00); // R5

  AST_WORD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !cs_n && busy); // R4

  AST_CRCZ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    crc_zero |-> done); // R6

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n ##1 !done && !busy); // R7

  AST_BUSY_REQ_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_start |=> $stable(addr_q)); // R8

endmodule

bind spi_burst_reader spi_rd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_start (req_start),
  .busy      (busy),
  .cs_n      (cs_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .pay_phase (pay_phase),
  .addr_q    (addr_q),
  .word_valid(word_valid),
  .done      (done),
  .crc_zero  (crc_zero)
);

// File: tb/test_spi_burst_reader.sv
module test_spi_burst_reader;

  localparam int MAX_WORDS = 64;
  localparam int CNT_W = $clog2(MAX_WORDS + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_start = 1'b0;
  logic [11:0]      req_addr = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic             busy, cs_n, tx_valid, word_valid, done, crc_zero;
  logic [7:0]       tx_data;
  logic             tx_ready = 1'b0;
  logic             rx_valid = 1'b0;
  logic [7:0]       rx_data = '0;
  logic [31:0]      word_data;

  spi_burst_reader #(.MAX_WORDS(MAX_WORDS)) i_spi_burst_reader (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_count(req_count), .busy(busy), .cs_n(cs_n), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .word_valid(word_valid), .word_data(word_data), .done(done), .crc_zero(crc_zero)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int frames = 0;
  logic [7:0] tx_log [0:511];
  logic [7:0]  miso_q [$];
  logic [31:0] exp_q [$];
  bit          exp_crc_q [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // shifter model: accepts an offered byte, returns a slave byte after a varying latency
  initial begin
    int frame_no = 0;
    forever begin
      @(negedge clk);
      tx_ready = 1'b0;
      rx_valid = 1'b0;
      if (cs_n) frame_no = 0;
      if (rst_n && tx_valid) begin
        tx_ready = 1'b1;
        if (frames < 512) tx_log[frames] = tx_data;
        frames++;
        @(negedge clk);
        tx_ready = 1'b0;
        repeat (frame_no % 3) @(negedge clk);
        rx_valid = 1'b1;
        if (frame_no < 2) rx_data = 8'hEE;
        else if (miso_q.size() > 0) rx_data = miso_q.pop_front();
        else rx_data = 8'h00;
        frame_no++;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && word_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected word", word_data, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(word_data == e, "R4 word order", word_data, e);
        end
      end
      if (rst_n && done) begin
        if (exp_crc_q.size() == 0) chk(1'b0, "R7 unexpected done", 1, 0);
        else begin
          bit e;
          e = exp_crc_q.pop_front();
          chk(crc_zero == e, "R6 crc_zero flag", crc_zero, e);
        end
      end
    end
  end

  task automatic run_read(input logic [11:0] addr, input int n, input logic [15:0] crc,
                          input bit poke);
    bit all_fill;
    frames = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = {addr, 20'h0} ^ (32'h1357_9BDF * (i + 1)) ^ 32'h00A5_5A00;
      exp_q.push_back(w);
      miso_q.push_back(w[31:24]);
      miso_q.push_back(w[23:16]);
      miso_q.push_back(w[15:8]);
      miso_q.push_back(w[7:0]);
    end
    miso_q.push_back(crc[15:8]);
    miso_q.push_back(crc[7:0]);
    exp_crc_q.push_back(crc == 16'h0000);
    @(negedge clk);
    req_addr = addr; req_count = CNT_W'(n); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(cs_n == 1'b0, "R2 cs_n low after request", cs_n, 0);
    if (poke) begin
      repeat (6) @(negedge clk);
      req_addr = ~addr; req_count = CNT_W'(3); req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(cs_n == 1'b1, "R7 cs_n high with done", cs_n, 1);
    @(negedge clk);
    chk(!busy && !done, "R7 busy and done low after done", {busy, done}, 0);
    chk(frames == 4 * n + 4, poke ? "R8 byte count with intruding request" : "R3 byte count",
        frames, 4 * n + 4);
    chk(miso_q.size() == 0, "R3 all slave bytes consumed", miso_q.size(), 0);
    chk(tx_log[0] == addr[11:4], "R1 header byte 0", tx_log[0], addr[11:4]);
    chk(tx_log[1] == {addr[3:0], 4'b1000}, "R1 header byte 1", tx_log[1], {addr[3:0], 4'b1000});
    all_fill = 1'b1;
    for (int k = 2; k < frames && k < 512; k++) if (tx_log[k] != 8'h00) all_fill = 1'b0;
    chk(all_fill, "R5 payload bytes zero", all_fill, 1);
    repeat (2) @(negedge clk);
    miso_q.delete();
  endtask

  task automatic try_reject(input int n);
    frames = 0;
    @(negedge clk);
    req_addr = 12'h123; req_count = CNT_W'(n); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(!busy && cs_n, "R9 rejected count leaves idle", {busy, cs_n}, 1);
    repeat (10) @(negedge clk);
    chk(frames == 0, "R9 no exchange for rejected count", frames, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R10 reset cs_n", cs_n, 1);
    chk({busy, tx_valid, word_valid, done, crc_zero} == 5'b0, "R10 reset outputs",
        {busy, tx_valid, word_valid, done, crc_zero}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy, "R10 idle after reset", {cs_n, busy}, 2);

    run_read(12'hABC, 1, 16'h1234, 1'b0);
    run_read(12'h001, 4, 16'h0000, 1'b0);
    run_read(12'hFFF, 2, 16'h0001, 1'b0);
    run_read(12'h800, 3, 16'h8000, 1'b0);
    run_read(12'h3A5, 2, 16'h5555, 1'b1);
    try_reject(0);
    try_reject(MAX_WORDS + 1);
    run_read(12'h5C3, MAX_WORDS, 16'h0000, 1'b0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected words seen", exp_q.size(), 0);
    chk(exp_crc_q.size() == 0, "R7 every transaction done", exp_crc_q.size(), 0);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule